// File: doc/BRIEF.md
# Enable-Gated Watchdog with Extended First Interval

This block supervises a processor through a heartbeat line and drives one active-low failover flag that hands control to backup logic. A synchronous enable input turns supervision on and off. While the enable is low, nothing is timed and the flag stays released. The enable input stands for a monitored supply that is above its threshold.

Each time the enable goes high, the first interval is `START_MULT` times the base period. This gives a slow-booting processor time to begin servicing. The first heartbeat falling edge ends this extended interval early, and from then on intervals last `BASE_CYCLES` clock cycles. Faults and recoveries are filtered by consecutive-event counting:

- The flag drops after `FAULT_LIMIT` back-to-back missed intervals, or at once when the extended interval runs out.
- The flag is released after `GOOD_LIMIT` punctual edges.

The heartbeat is asynchronous. It is synchronized inside the block, and only its falling edges count.

Top module: `gated_start_watchdog`

## Requirements
- R1: While `en_i` is low, no interval is timed and `failover_n_o` is 1. The reset state of `failover_n_o` is 1.
- R2: After each low-to-high change of `en_i`, the first interval is `BASE_CYCLES*START_MULT` cycles long if no heartbeat edge arrives in it.
- R3: A heartbeat falling edge during the extended interval ends that interval at once. Every later interval is `BASE_CYCLES` cycles long.
- R4: If the extended interval runs out with no heartbeat edge, `failover_n_o` goes to 0 at the end of that interval and stays 0.
- R5: After an extended interval has run out, timing continues in `BASE_CYCLES` periods, so edges spaced more than `BASE_CYCLES` apart never release the flag.
- R6: `FAULT_LIMIT` consecutive base intervals without a heartbeat falling edge drive `failover_n_o` to 0. Any heartbeat edge clears the run of misses.
- R7: While `failover_n_o` is 0, it returns to 1 after `GOOD_LIMIT` heartbeat edges. Each of these edges must follow the previous edge with no interval expiry between them. An expiry restarts this count, and the edge after an expiry only serves as the reference edge.
- R8: When `en_i` falls, the interval counter and both event counters are cleared, and `failover_n_o` is 1 from the next cycle.
- R9: `heartbeat_i` passes through `SYNC_STAGES` flip-flops. Only a high-to-low change is a heartbeat, so a line held low does not restart timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Supervision enable, synchronous to `clk` |
| heartbeat_i | input | 1 | Asynchronous heartbeat line; its falling edges are service events |
| failover_n_o | output | 1 | Active-low failover flag |

## Verification
The bench builds the block with `BASE_CYCLES=20` and keeps the default multiplier of 8, so the extended interval is 160 cycles. With these values the extended expiry, a collapse after one edge, and three base-period misses all fit within a few hundred cycles. Heartbeat spacings of 12, 15 and 25 cycles fall clearly on either side of the 20-cycle period. This keeps punctual and late edges apart, while allowing for the three-cycle input latency of the synchronizer and edge detector.

// File: rtl/gsw_pkg.sv
package gsw_pkg;

  // Length of the current interval in clock cycles.
  function automatic int unsigned interval_len(input logic extended,
                                               input int unsigned base,
                                               input int unsigned mult);
    return extended ? base * mult : base;
  endfunction

  // Next value of a counter that saturates at lim.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/gsw_hb_edge.sv
module gsw_hb_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hb_i,
  output logic hb_fall_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         prev_q;

  // The line idles high, so the chain resets to ones and no edge appears after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[MSB-1:0], hb_i};
      prev_q <= sync_q[MSB];
    end
  end

  assign hb_fall_o = prev_q & ~sync_q[MSB];

  AST_FALL_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hb_fall_o |=> !hb_fall_o); // R9
endmodule

// File: rtl/gsw_interval_timer.sv
module gsw_interval_timer
  import gsw_pkg::*;
#(
  parameter int unsigned BASE_CYCLES = 1000,
  parameter int unsigned START_MULT  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic hb_fall_i,
  output logic expire_o,
  output logic ext_expire_o,
  output logic ext_mode_o
);
  localparam int unsigned LONG_CYCLES = BASE_CYCLES * START_MULT;
  localparam int unsigned CW          = $clog2(LONG_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          ext_q;   // armed while idle, so every enable rise starts extended
  logic [CW-1:0] last_tick;

  assign last_tick    = CW'(interval_len(ext_q, BASE_CYCLES, START_MULT) - 1);
  assign expire_o     = en_i && !hb_fall_i && (cnt_q == last_tick);
  assign ext_expire_o = expire_o && ext_q;
  assign ext_mode_o   = ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ext_q <= 1'b1;
    end else if (!en_i) begin
      cnt_q <= '0;
      ext_q <= 1'b1;
    end else if (hb_fall_i || expire_o) begin
      cnt_q <= '0;
      ext_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_COUNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_tick); // R2
  AST_EXT_ARMS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_q) |-> $past(!en_i)); // R2
  AST_EDGE_ENDS_EXTENDED: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && hb_fall_i |=> !ext_q); // R3
endmodule

// File: rtl/gsw_fail_hyst.sv
module gsw_fail_hyst
  import gsw_pkg::*;
#(
  parameter int unsigned FAULT_LIMIT = 3,
  parameter int unsigned GOOD_LIMIT  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic hb_fall_i,
  input  logic expire_i,
  input  logic ext_expire_i,
  output logic good_edge_o,
  output logic fail_n_o
);
  localparam int unsigned FW = $clog2(FAULT_LIMIT + 1);
  localparam int unsigned GW = $clog2(GOOD_LIMIT + 1);

  logic [FW-1:0] fault_q;
  logic [GW-1:0] good_q;
  logic          clean_q;  // no expiry since the previous edge
  logic          fail_n_q;

  assign good_edge_o = en_i && hb_fall_i && clean_q;
  assign fail_n_o    = fail_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q  <= '0;
      good_q   <= '0;
      clean_q  <= 1'b1;
      fail_n_q <= 1'b1;
    end else if (!en_i) begin
      fault_q  <= '0;
      good_q   <= '0;
      clean_q  <= 1'b1;
      fail_n_q <= 1'b1;
    end else if (hb_fall_i) begin
      fault_q <= '0;
      clean_q <= 1'b1;
      if (!fail_n_q && clean_q) begin
        if (good_q == GW'(GOOD_LIMIT - 1)) begin
          fail_n_q <= 1'b1;
          good_q   <= '0;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end
    end else if (expire_i) begin
      clean_q <= 1'b0;
      good_q  <= '0;
      fault_q <= FW'(sat_inc(fault_q, FAULT_LIMIT));
      if (ext_expire_i || fault_q >= FW'(FAULT_LIMIT - 1)) fail_n_q <= 1'b0;
    end
  end

  AST_FAULT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q <= FW'(FAULT_LIMIT)); // R6
  AST_DROP_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fail_n_q) |-> $past(expire_i)); // R6
  AST_RELEASE_ON_GOOD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_i) && $rose(fail_n_q) |-> $past(good_edge_o)); // R7
endmodule

// File: rtl/gated_start_watchdog.sv
module gated_start_watchdog #(
  parameter int unsigned BASE_CYCLES = 1000,
  parameter int unsigned START_MULT  = 8,
  parameter int unsigned FAULT_LIMIT = 3,
  parameter int unsigned GOOD_LIMIT  = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic heartbeat_i,
  output logic failover_n_o
);
  logic hb_fall;
  logic expire;
  logic ext_expire;
  logic ext_mode;
  logic good_edge;

  gsw_hb_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .hb_i(heartbeat_i), .hb_fall_o(hb_fall)
  );

  gsw_interval_timer #(.BASE_CYCLES(BASE_CYCLES), .START_MULT(START_MULT)) u_timer (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .hb_fall_i(hb_fall),
    .expire_o(expire), .ext_expire_o(ext_expire), .ext_mode_o(ext_mode)
  );

  gsw_fail_hyst #(.FAULT_LIMIT(FAULT_LIMIT), .GOOD_LIMIT(GOOD_LIMIT)) u_hyst (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .hb_fall_i(hb_fall),
    .expire_i(expire), .ext_expire_i(ext_expire),
    .good_edge_o(good_edge), .fail_n_o(failover_n_o)
  );

  AST_EXT_EXPIRY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ext_expire |=> !failover_n_o); // R4
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> failover_n_o); // R8
  AST_EXT_EXPIRY_ONLY_EXTENDED: assert property (@(posedge clk) disable iff (!rst_n)
    ext_expire |-> ext_mode && !good_edge); // R4
endmodule

// File: tb/sim_gated_start_watchdog.sv
`timescale 1ns/1ps
module sim_gated_start_watchdog;
  localparam int unsigned BASE = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic hb = 1'b1;
  logic fail_n;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gated_start_watchdog #(.BASE_CYCLES(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en), .heartbeat_i(hb), .failover_n_o(fail_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_flag(input logic exp, input string req, input string what);
    checks++;
    if (fail_n !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, fail_n, exp);
    end
  endtask

  // One heartbeat falling edge; the line is back high after three cycles.
  task automatic beat();
    hb = 1'b0; tick(3); hb = 1'b1;
  endtask

  task automatic restart_enable();
    en = 1'b0; tick(2); en = 1'b1;
  endtask

  task automatic t_reset_and_idle();
    expect_flag(1'b1, "R1", "reset state");
    rst_n = 1'b1; tick(2);
    for (int i = 0; i < 5; i++) begin beat(); tick(60); end
    expect_flag(1'b1, "R1", "no timing while enable low");
  endtask

  task automatic t_extended_expiry();
    en = 1'b1;
    tick(150); expect_flag(1'b1, "R2", "still inside extended interval");
    tick(15);  expect_flag(1'b0, "R4", "extended interval expired");
    tick(100); expect_flag(1'b0, "R4", "flag stays low");
    en = 1'b0; tick(2);
    expect_flag(1'b1, "R8", "released when enable falls");
  endtask

  task automatic t_collapse();
    en = 1'b1; tick(30); beat();
    tick(40); expect_flag(1'b1, "R6", "two base misses only");
    tick(30); expect_flag(1'b0, "R3", "base period after first edge");
  endtask

  task automatic t_consecutive();
    restart_enable(); beat();
    for (int i = 0; i < 3; i++) begin
      tick(45); expect_flag(1'b1, "R6", "edge clears run of misses");
      beat();
    end
    tick(70); expect_flag(1'b0, "R6", "three base misses");
  endtask

  task automatic t_level();
    restart_enable(); tick(2);
    expect_flag(1'b1, "R8", "counters cleared on re-enable");
    beat(); hb = 1'b0; tick(80);
    expect_flag(1'b0, "R9", "held low line is not a heartbeat");
    hb = 1'b1; tick(5);
    expect_flag(1'b0, "R9", "rising edge is not a heartbeat");
  endtask

  task automatic t_late_then_release();
    restart_enable(); tick(170);
    expect_flag(1'b0, "R4", "second extended expiry");
    beat();
    for (int i = 0; i < 3; i++) begin tick(22); beat(); end
    tick(3); expect_flag(1'b0, "R5", "late edges do not release");
    for (int i = 0; i < 2; i++) begin tick(9); beat(); end
    tick(3); expect_flag(1'b0, "R7", "two punctual edges not enough");
    tick(9); beat(); tick(3);
    expect_flag(1'b1, "R7", "third punctual edge releases");
  endtask

  task automatic t_steady();
    for (int i = 0; i < 20; i++) begin
      tick(12); beat();
      expect_flag(1'b1, "R6", "steady heartbeat keeps flag high");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    t_reset_and_idle();
    t_extended_expiry();
    t_collapse();
    t_consecutive();
    t_level();
    t_late_then_release();
    t_steady();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end
endmodule